// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core

This block is a clocked SRAM with registered address, control, write-data and read-data stages around an internal array. Each access starts with one of two address strobes. The processor strobe is honoured only when chip enable is low, and it always starts a read. The controller strobe is honoured at any time. If it arrives while the chip is selected, it starts a read or a write according to the write controls sampled in the same cycle. If it arrives while the chip is not selected, it deselects the chip. Later cycles without a strobe continue the burst. The burst address steps through a four-word group, either in wrap-around linear order or in XOR (interleaved) order, or holds still when the advance input is inactive.

Read data leaves through a registered output stage, so the first word appears one clock after the address is registered. Deselect and write cycles turn the output drive off after exactly one stage. The pad drive is formed by the registered drive flag gated with an output-enable input that acts at once, without waiting for a clock. A sleep input freezes every register and the array, so the block resumes from where it stopped. The tri-state bus is given as separate input, output and drive-enable signals, ready for a pad cell.

Top module: `sync_sram_core`

## Requirements
- R1: The chip counts as selected only when `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0 at the clock edge. A strobe cycle taken while the chip is not selected starts no access, and the bus stays undriven.
- R2: A read that starts at edge k drives `dq_drive`=1 and the stored word on `dq_out` after edge k+1, not earlier (with `out_en_n`=0).
- R3: A low `cpu_as_n` while `ce_n`=1 is ignored. A running burst continues as if no strobe had been seen.
- R4: When both strobes are low in the same cycle, the processor strobe wins. The cycle is a read and all write controls are ignored.
- R5: The write mask is formed per lane. `all_wr_n`=0 writes all lanes. Otherwise, `lane_gate_n`=0 writes each lane i whose `lane_wr_n[i]`=0, where lane i is bits 9i+8..9i. Otherwise nothing is written. A controller-strobe cycle with an empty mask is a read.
- R6: In a burst, `adv_n`=0 steps the word counter, and `adv_n`=1 keeps the same address. The two low address bits are base+count mod 4 when `order_ilv`=0, and base XOR count when `order_ilv`=1. The count wraps after four words. The bits above them stay fixed. Continuing cycles can also write.
- R7: `dq_drive` is low whenever `out_en_n`=1, and it follows `out_en_n` with no clock edge in between.
- R8: After a deselect or write cycle sampled at edge k, the bus is still driven by the previous read after edge k and is undriven after edge k+1.
- R9: While `sleep_i`=1, no register or array word changes whatever the other inputs do. After `sleep_i` returns to 0, the pipeline continues from its pre-sleep state.
- R10: After reset the bus is undriven and no burst is active, so cycles without a strobe drive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr_i | input | ADDR_W | Word address, taken on a strobe cycle |
| cpu_as_n | input | 1 | Processor address strobe, active low, gated by ce_n |
| ctl_as_n | input | 1 | Controller address strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_gate_n | input | 1 | Enables the per-lane writes, active low |
| lane_wr_n | input | NUM_BYTES | Per-lane write selects, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Output enable, active low, acts at once |
| sleep_i | input | 1 | Freeze all state while high |
| dq_in | input | NUM_BYTES*BYTE_W | Write data from the pad |
| dq_out | output | NUM_BYTES*BYTE_W | Read data to the pad |
| dq_drive | output | 1 | Pad driver enable |

## Verification
The bench compares every cycle against a behavioural model. It first runs single-word reads after a deselect, which settles the one-cycle latency. Linear bursts from a base of 2 and interleaved bursts from a base of 1 then give different word orders, so a swapped or broken order shows as a wrong word, and a fifth linear step shows the wrap. Patterns with a partial lane mask, a gated-off mask and both strobes low tell a real write apart from a read that must leave memory untouched. A stray processor strobe with chip enable high, each of the three deselect conditions, and a sleep window with write strobes pending separate ignored inputs from the ones that act.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;

    // Words per burst group and the counter width that walks it.
    localparam int BURST_LEN = 4;
    localparam int BCNT_W    = $clog2(BURST_LEN);

    // What the current cycle does to the access pipeline.
    typedef enum logic [2:0] {
        CK_IDLE,      // no strobe, no burst running
        CK_DESEL,     // strobe while not selected
        CK_LOAD_CPU,  // processor strobe: new read
        CK_LOAD_CTL,  // controller strobe: new read or write
        CK_CONT       // burst continuation
    } cyc_kind_e;

endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
    import sram_core_pkg::*;
(
    input  logic      ce_n,
    input  logic      cs_hi,
    input  logic      cs_lo_n,
    input  logic      cpu_as_n,
    input  logic      ctl_as_n,
    input  logic      burst_act,
    output cyc_kind_e kind
);

    logic sel;
    logic cpu_go;
    logic ctl_go;

    always_comb begin
        sel    = !ce_n && cs_hi && !cs_lo_n;
        // processor strobe only counts with chip enable low
        cpu_go = !cpu_as_n && !ce_n;
        ctl_go = !ctl_as_n;
        if (cpu_go || ctl_go) begin
            if (!sel) begin
                kind = CK_DESEL;
            end else if (cpu_go) begin
                kind = CK_LOAD_CPU;   // processor strobe wins a tie
            end else begin
                kind = CK_LOAD_CTL;
            end
        end else if (burst_act) begin
            kind = CK_CONT;
        end else begin
            kind = CK_IDLE;
        end
    end

endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] mask
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = !all_wr_n || (!lane_gate_n && !lane_wr_n[i]);
    end

endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
    import sram_core_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BCNT_W-1:0] cnt,
    input  logic              step,
    input  logic              interleave,
    output logic [BCNT_W-1:0] cnt_nxt,
    output logic [ADDR_W-1:0] addr_nxt
);

    logic [BCNT_W-1:0] lo_lin;
    logic [BCNT_W-1:0] lo_ilv;

    always_comb begin
        cnt_nxt  = step ? cnt + BCNT_W'(1) : cnt;
        lo_lin   = base[BCNT_W-1:0] + cnt_nxt;
        lo_ilv   = base[BCNT_W-1:0] ^ cnt_nxt;
        addr_nxt = base;
        addr_nxt[BCNT_W-1:0] = interleave ? lo_ilv : lo_lin;
    end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        wmask,
    input  logic [LANES*BYTE_W-1:0] wdata,
    input  logic                    re,
    output logic [LANES*BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANES-1:0][BYTE_W-1:0] mem [DEPTH];
    logic [LANES-1:0][BYTE_W-1:0] wlanes;

    assign wlanes = wdata;

    // Array words carry no reset: contents persist across sleep.
    always_ff @(posedge clk) begin
        if (en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wmask[i]) begin
                    mem[addr][i] <= wlanes[i];
                end
            end
        end
    end

    // Output register of the read path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/sync_sram_core.sv
module sync_sram_core
    import sram_core_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BYTE_W    = 9,
    parameter int NUM_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        cpu_as_n,
    input  logic                        ctl_as_n,
    input  logic                        ce_n,
    input  logic                        cs_hi,
    input  logic                        cs_lo_n,
    input  logic                        adv_n,
    input  logic                        all_wr_n,
    input  logic                        lane_gate_n,
    input  logic [NUM_BYTES-1:0]        lane_wr_n,
    input  logic                        order_ilv,
    input  logic                        out_en_n,
    input  logic                        sleep_i,
    input  logic [NUM_BYTES*BYTE_W-1:0] dq_in,
    output logic [NUM_BYTES*BYTE_W-1:0] dq_out,
    output logic                        dq_drive
);

    localparam int DATA_W = NUM_BYTES * BYTE_W;

    typedef struct packed {
        logic                 act;      // burst in progress
        logic [ADDR_W-1:0]    base;     // address the burst started at
        logic [BCNT_W-1:0]    cnt;      // words stepped so far
        logic                 rd;       // pending read for the output stage
        logic [NUM_BYTES-1:0] wmask;    // pending lane writes
        logic [ADDR_W-1:0]    op_addr;  // address of the pending operation
        logic [DATA_W-1:0]    din;      // registered write data
        logic                 drive;    // output stage holds a read word
    } core_st_t;

    core_st_t st_d;
    core_st_t st_q;

    cyc_kind_e            kind;
    logic [NUM_BYTES-1:0] mask;
    logic [BCNT_W-1:0]    cnt_nxt;
    logic [ADDR_W-1:0]    burst_addr;
    logic [DATA_W-1:0]    rdata;

    sram_cycle_decode i_decode (
        .ce_n      (ce_n),
        .cs_hi     (cs_hi),
        .cs_lo_n   (cs_lo_n),
        .cpu_as_n  (cpu_as_n),
        .ctl_as_n  (ctl_as_n),
        .burst_act (st_q.act),
        .kind      (kind)
    );

    sram_lane_mask #(.LANES(NUM_BYTES)) i_mask (
        .all_wr_n    (all_wr_n),
        .lane_gate_n (lane_gate_n),
        .lane_wr_n   (lane_wr_n),
        .mask        (mask)
    );

    sram_burst_seq #(.ADDR_W(ADDR_W)) i_burst (
        .base       (st_q.base),
        .cnt        (st_q.cnt),
        .step       (!adv_n),
        .interleave (order_ilv),
        .cnt_nxt    (cnt_nxt),
        .addr_nxt   (burst_addr)
    );

    sram_array #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .LANES  (NUM_BYTES)
    ) i_array (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (!sleep_i),
        .addr  (st_q.op_addr),
        .wmask (st_q.wmask),
        .wdata (st_q.din),
        .re    (st_q.rd),
        .rdata (rdata)
    );

    always_comb begin
        st_d = st_q;
        if (!sleep_i) begin
            st_d.drive = st_q.rd;
            case (kind)
                CK_DESEL: begin
                    st_d.act   = 1'b0;
                    st_d.rd    = 1'b0;
                    st_d.wmask = '0;
                end
                CK_LOAD_CPU: begin
                    st_d.act     = 1'b1;
                    st_d.base    = addr_i;
                    st_d.cnt     = '0;
                    st_d.op_addr = addr_i;
                    st_d.rd      = 1'b1;
                    st_d.wmask   = '0;
                    st_d.din     = dq_in;
                end
                CK_LOAD_CTL: begin
                    st_d.act     = 1'b1;
                    st_d.base    = addr_i;
                    st_d.cnt     = '0;
                    st_d.op_addr = addr_i;
                    st_d.rd      = (mask == '0);
                    st_d.wmask   = mask;
                    st_d.din     = dq_in;
                end
                CK_CONT: begin
                    st_d.cnt     = cnt_nxt;
                    st_d.op_addr = burst_addr;
                    st_d.rd      = (mask == '0);
                    st_d.wmask   = mask;
                    st_d.din     = dq_in;
                end
                default: begin
                    st_d.rd    = 1'b0;
                    st_d.wmask = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out   = rdata;
    assign dq_drive = st_q.drive && !out_en_n;

endmodule

// File: rtl/sync_sram_core_chk.sv
module sync_sram_core_chk #(
    parameter int ADDR_W    = 8,
    parameter int BYTE_W    = 9,
    parameter int NUM_BYTES = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cpu_as_n,
    input logic                        ctl_as_n,
    input logic                        ce_n,
    input logic                        cs_hi,
    input logic                        cs_lo_n,
    input logic                        all_wr_n,
    input logic                        out_en_n,
    input logic                        sleep_i,
    input logic [NUM_BYTES*BYTE_W-1:0] dq_out,
    input logic                        dq_drive
);

    logic sel;
    logic desel_go;
    logic cpu_rd_go;
    logic full_wr_go;

    assign sel        = !ce_n && cs_hi && !cs_lo_n;
    assign desel_go   = !sleep_i && !sel && (!ctl_as_n || (!cpu_as_n && !ce_n));
    assign cpu_rd_go  = !sleep_i && sel && !cpu_as_n;
    assign full_wr_go = !sleep_i && sel && cpu_as_n && !ctl_as_n && !all_wr_n;

    // R7
    oe_gates_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dq_drive);

    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desel_go ##1 !sleep_i |=> !dq_drive);

    // R8
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_wr_go ##1 !sleep_i |=> !dq_drive);

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd_go ##1 (!sleep_i && !out_en_n) |=> dq_drive);

    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && dq_drive) |=> $stable(dq_out));

endmodule

bind sync_sram_core sync_sram_core_chk #(
    .ADDR_W    (ADDR_W),
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES)
) i_chk (.*);

// File: tb/test_sync_sram_core.sv
module test_sync_sram_core;

    localparam int AW = 8;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          cpu_as_n = 1'b1, ctl_as_n = 1'b1, ce_n = 1'b0, cs_hi = 1'b1, cs_lo_n = 1'b0;
    logic          adv_n = 1'b1, all_wr_n = 1'b1, lane_gate_n = 1'b1;
    logic [3:0]    lane_wr_n = 4'hF;
    logic          order_ilv = 1'b0, out_en_n = 1'b0, sleep_i = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_drive;

    int    checks = 0;
    int    bad = 0;
    bit    done = 0;
    string phase = "R10";

    always #4 clk = ~clk;

    sync_sram_core i_sync_sram_core (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cpu_as_n(cpu_as_n), .ctl_as_n(ctl_as_n),
        .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .adv_n(adv_n), .all_wr_n(all_wr_n),
        .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n), .order_ilv(order_ilv),
        .out_en_n(out_en_n), .sleep_i(sleep_i), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a) * 36'h0_9E37_79B1 + 36'h5;
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] mdl_mem [int];
    bit            m_act, p_rd, mdl_drive;
    int            m_base, m_cnt, p_addr;
    logic [3:0]    p_wm;
    logic [DW-1:0] p_din, mdl_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; p_rd = 0; p_wm = 0; mdl_drive = 0; mdl_data = '0;
        end else if (!sleep_i) begin
            bit sel, cpu, ctl;
            logic [3:0] wm;
            if (p_wm != 0) begin
                logic [DW-1:0] w;
                w = mdl_mem.exists(p_addr) ? mdl_mem[p_addr] : 'x;
                for (int b = 0; b < 4; b++) if (p_wm[b]) w[b*9 +: 9] = p_din[b*9 +: 9];
                mdl_mem[p_addr] = w;
            end
            if (p_rd) mdl_data = mdl_mem[p_addr];
            mdl_drive = p_rd;
            sel = !ce_n && cs_hi && !cs_lo_n;
            cpu = !cpu_as_n && !ce_n;
            ctl = !ctl_as_n;
            for (int b = 0; b < 4; b++) wm[b] = !all_wr_n || (!lane_gate_n && !lane_wr_n[b]);
            if (cpu || ctl) begin
                if (!sel) begin
                    m_act = 0; p_rd = 0; p_wm = 0;
                end else begin
                    m_act = 1; m_base = int'(addr_i); m_cnt = 0; p_addr = int'(addr_i); p_din = dq_in;
                    if (cpu) begin p_rd = 1; p_wm = 0; end
                    else begin p_wm = wm; p_rd = (wm == 0); end
                end
            end else if (m_act) begin
                if (!adv_n) m_cnt = (m_cnt + 1) % 4;
                p_addr = (m_base & ~3) | (order_ilv ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) % 4));
                p_wm = wm; p_rd = (wm == 0); p_din = dq_in;
            end else begin
                p_rd = 0; p_wm = 0;
            end
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        bit exp_dr;
        #2;
        if (rst_n && !done) begin
            checks++;
            exp_dr = mdl_drive && !out_en_n;
            if (dq_drive !== exp_dr || (exp_dr && dq_out !== mdl_data)) begin
                bad++;
                $display("FAIL %s model: actual drive=%0b data=%h expected drive=%0b data=%h",
                         phase, dq_drive, dq_out, exp_dr, mdl_data);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cpu_as_n = 1; ctl_as_n = 1; adv_n = 1; all_wr_n = 1; lane_gate_n = 1; lane_wr_n = 4'hF;
        ce_n = 0; cs_hi = 1; cs_lo_n = 0;
    endtask

    task automatic wr_start(input int a, input logic [DW-1:0] d);
        idle(); ctl_as_n = 0; all_wr_n = 0; addr_i = AW'(a); dq_in = d;
        tick(); idle();
    endtask

    task automatic rd_start(input int a);
        idle(); cpu_as_n = 0; addr_i = AW'(a);
        tick(); idle();
    endtask

    task automatic desel();
        idle(); ctl_as_n = 0; ce_n = 1;
        tick(); idle();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] nd, m10;
        int lin [5];
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10: idle after reset
        phase = "R10";
        chk("R10 drive after reset", DW'(dq_drive), '0);
        tick(); tick();
        chk("R10 no burst after reset", DW'(dq_drive), '0);

        // fill memory
        phase = "R5";
        for (int a = 16'h10; a <= 16'h13; a++) wr_start(a, pat(a));
        for (int a = 16'h20; a <= 16'h23; a++) wr_start(a, pat(a));
        for (int a = 16'h30; a <= 16'h33; a++) wr_start(a, pat(a));
        // R6 write burst from 0x26: 26,27,24,25
        phase = "R6";
        wr_start(16'h26, pat(16'h26));
        all_wr_n = 0; adv_n = 0; dq_in = pat(16'h27); tick();
        dq_in = pat(16'h24); tick();
        dq_in = pat(16'h25); tick();
        desel();

        // R2 latency
        phase = "R2";
        rd_start(16'h10);
        chk("R2 not yet driven", DW'(dq_drive), '0);
        tick();
        chk("R2 drive", DW'(dq_drive), 1);
        chk("R2 data", dq_out, pat(16'h10));

        // R6 linear burst with wrap
        phase = "R6";
        lin = '{16'h22, 16'h23, 16'h20, 16'h21, 16'h22};
        rd_start(16'h22);
        for (int i = 0; i < 5; i++) begin
            adv_n = 0; tick();
            chk("R6 linear order", dq_out, pat(lin[i]));
        end
        idle();
        // R6 interleaved burst from 0x31
        order_ilv = 1;
        rd_start(16'h31);
        for (int i = 0; i < 4; i++) begin
            adv_n = 0; tick();
            chk("R6 interleaved order", dq_out, pat(16'h30 | (1 ^ i)));
        end
        idle(); order_ilv = 0;
        // R6 hold with adv_n high
        rd_start(16'h11);
        tick(); chk("R6 hold", dq_out, pat(16'h11));
        tick(); chk("R6 hold again", dq_out, pat(16'h11));
        // R6 burst-written words
        rd_start(16'h24);
        adv_n = 0; tick(); chk("R6 burst write word 24", dq_out, pat(16'h24));
        tick(); chk("R6 burst write word 25", dq_out, pat(16'h25));
        idle();

        // R5 lane write on bytes 0 and 2
        phase = "R5";
        nd = 36'hA_BCDE_F012;
        m10 = pat(16'h10);
        m10[8:0] = nd[8:0];
        m10[26:18] = nd[26:18];
        idle(); ctl_as_n = 0; addr_i = 8'h10; lane_gate_n = 0; lane_wr_n = 4'b1010; dq_in = nd;
        tick(); idle();
        tick();
        chk("R5 write turns drive off", DW'(dq_drive), '0);
        rd_start(16'h10); tick();
        chk("R5 partial lanes", dq_out, m10);
        // R5 gate off: becomes a read
        idle(); ctl_as_n = 0; addr_i = 8'h11; lane_wr_n = 4'h0; dq_in = '1;
        tick(); idle(); tick();
        chk("R5 gated lanes read", dq_out, pat(16'h11));

        // R4 both strobes low: read wins
        phase = "R4";
        idle(); cpu_as_n = 0; ctl_as_n = 0; all_wr_n = 0; addr_i = 8'h12; dq_in = '0;
        tick(); idle(); tick();
        chk("R4 tie is a read", dq_out, pat(16'h12));
        rd_start(16'h12); tick();
        chk("R4 memory untouched", dq_out, pat(16'h12));

        // R3 processor strobe with ce_n high is ignored
        phase = "R3";
        rd_start(16'h20);
        for (int i = 0; i < 4; i++) begin
            adv_n = 0;
            if (i == 1) begin cpu_as_n = 0; ce_n = 1; addr_i = 8'h13; end
            tick();
            idle();
            chk("R3 burst continues", dq_out, pat(16'h20 + i));
        end

        // R8 / R1 deselect
        phase = "R8";
        rd_start(16'h13); tick();
        idle(); ctl_as_n = 0; cs_hi = 0; tick(); idle();
        chk("R8 still driven one stage", DW'(dq_drive), 1);
        tick();
        chk("R8 off after one stage", DW'(dq_drive), '0);
        phase = "R1";
        idle(); cpu_as_n = 0; cs_lo_n = 1; addr_i = 8'h13; tick(); idle(); tick();
        chk("R1 cs_lo_n high", DW'(dq_drive), '0);
        idle(); ctl_as_n = 0; ce_n = 1; addr_i = 8'h13; tick(); idle(); tick();
        chk("R1 ce_n high", DW'(dq_drive), '0);
        tick();
        chk("R1 no burst after deselect", DW'(dq_drive), '0);

        // R7 asynchronous output enable
        phase = "R7";
        rd_start(16'h13); tick();
        chk("R7 driven", DW'(dq_drive), 1);
        out_en_n = 1; #1;
        chk("R7 off at once", DW'(dq_drive), '0);
        out_en_n = 0; #1;
        chk("R7 on at once", DW'(dq_drive), 1);

        // R9 sleep freezes everything
        phase = "R9";
        sleep_i = 1;
        idle(); ctl_as_n = 0; all_wr_n = 0; addr_i = 8'h13; dq_in = '0; adv_n = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R9 data frozen", dq_out, pat(16'h13));
            chk("R9 drive frozen", DW'(dq_drive), 1);
        end
        sleep_i = 0; idle(); adv_n = 0;
        tick();
        chk("R9 resume pending read", dq_out, pat(16'h13));
        adv_n = 1;
        tick();
        chk("R9 resume burst step", dq_out, m10);
        rd_start(16'h13); tick();
        chk("R9 contents retained", dq_out, pat(16'h13));

        done = 1;
        summary();
        $finish;
    end

endmodule